// File: doc/BRIEF.md
# Grouped-Priority Interrupt Arbiter

This block looks at a set of interrupt request lines, each tagged with a programmable 8-bit urgency value, and names the line that should be serviced next. A smaller value means a more urgent request. A 3-bit split control divides every value into two fields. The high-order bits form the group level. The low-order bits form the sub-level, and the split control gives their count, from none up to seven.

Two decisions come out of the arbiter. The first is the winner among the pending lines. It is chosen by group level, then by sub-level, then by the lowest line number. The second is whether that winner may interrupt the handler now running. This depends only on the group levels: the winner's group level must be strictly smaller than the group level of the active urgency value, which is an input. When no handler is running, any pending winner may be taken. A request whose group level matches the running handler stays pending.

The selection is fully combinational across all lines and is registered once. The three outputs therefore describe the inputs sampled at the previous rising clock edge, and they refresh on every cycle.

Top module: `gpa_arbiter`

## Requirements
- R1: While reset is high, and on the first edge where it is seen high, the outputs are cleared to win_valid=0, win_idx=0 and preempt=0.
- R2: win_valid is 1 exactly when at least one bit of req was 1 at the previous rising clock edge, so the outputs lag the inputs by one cycle.
- R3: Among requesting lines whose group levels differ, the line with the smaller group level wins, whatever its line number.
- R4: The sub-level is the lowest split_sel bits of a line's value and the group level is the remaining upper bits. split_sel=0 makes all 8 bits the group level, and split_sel=7 leaves only bit 7 as the group level.
- R5: Among requesting lines with equal group level, the line with the smaller sub-level wins.
- R6: Among requesting lines with equal group level and equal sub-level, the line with the lowest index wins.
- R7: When act_valid=1, preempt is 1 when the winner's group level is strictly below the group level of act_prio, both split by the same split_sel.
- R8: When act_valid=1 and the winner's group level equals the group level of act_prio, preempt is 0, even if the winner's sub-level is lower.
- R9: When act_valid=0, preempt equals win_valid.
- R10: When no line requests, win_valid=0, win_idx=0 and preempt=0.
- R11: The value of a line whose req bit is 0 has no effect on the winner, even when that value is the most urgent one present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NUM_REQ | Pending request lines, one bit per line |
| prio_flat | input | NUM_REQ*8 | Urgency values; line i uses bits [8*i+7:8*i] |
| split_sel | input | 3 | Number of low-order bits that form the sub-level (0 to 7) |
| act_valid | input | 1 | A handler is currently running |
| act_prio | input | 8 | Urgency value of the running handler |
| win_valid | output | 1 | Registered: some line was requesting |
| win_idx | output | $clog2(NUM_REQ) | Registered index of the selected line |
| preempt | output | 1 | Registered: the selected line may interrupt the running handler |

## Verification
Directed patterns are used to separate the three ordering keys. Values that differ in their upper bits show that the group level dominates the line number. Values that share a group level and differ only in low bits show that the sub-level is honoured. Identical values placed on spread-out lines show the lowest-index tie-break. The same pair of values is tried under several split_sel settings, which shows that the split point moves the boundary between a preempting and a non-preempting comparison. A very urgent value is also placed on a line that is not requesting, to show that idle lines are masked. A mid-cycle sample shows that the outputs lag the inputs by one register.

// File: rtl/gpa_pkg.sv
package gpa_pkg;

    localparam int PRIO_W = 8;
    localparam int SEL_W  = 3;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [SEL_W-1:0]  sel_t;

    typedef struct packed {
        logic  vld;
        prio_t grp;
        prio_t sub;
    } key_t;

    function automatic prio_t grp_of(input prio_t v, input sel_t s);
        return v >> s;
    endfunction

    function automatic prio_t sub_of(input prio_t v, input sel_t s);
        prio_t m;
        m = ~(prio_t'('1) << s);
        return v & m;
    endfunction

    // a strictly more urgent than b (valid bits ignored)
    function automatic logic key_less(input key_t a, input key_t b);
        if (a.grp != b.grp) return a.grp < b.grp;
        return a.sub < b.sub;
    endfunction

endpackage

// File: rtl/gpa_key_split.sv
module gpa_key_split
    import gpa_pkg::*;
#(
    parameter int NUM_REQ = 16
) (
    input  logic [NUM_REQ-1:0]        req,
    input  logic [NUM_REQ*PRIO_W-1:0] prio_flat,
    input  sel_t                      split_sel,
    output key_t [NUM_REQ-1:0]        keys
);

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_line
        prio_t val;
        assign val          = prio_flat[i*PRIO_W +: PRIO_W];
        assign keys[i].vld  = req[i];
        assign keys[i].grp  = grp_of(val, split_sel);
        assign keys[i].sub  = sub_of(val, split_sel);
    end

endmodule

// File: rtl/gpa_select_tree.sv
module gpa_select_tree
    import gpa_pkg::*;
#(
    parameter int NUM_REQ = 16,
    localparam int IW     = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
    localparam int LEAVES = 1 << $clog2(NUM_REQ)
) (
    input  key_t [NUM_REQ-1:0] keys,
    output logic               best_vld,
    output logic [IW-1:0]      best_idx,
    output prio_t              best_grp
);

    typedef struct packed {
        key_t          k;
        logic [IW-1:0] idx;
    } node_t;

    node_t nodes [1:2*LEAVES-1];

    for (genvar l = 0; l < LEAVES; l++) begin : g_leaf
        if (l < NUM_REQ) begin : g_real
            assign nodes[LEAVES+l] = '{k: keys[l], idx: IW'(l)};
        end else begin : g_pad
            assign nodes[LEAVES+l] = '0;
        end
    end

    // left child holds lower indices, so it keeps ties
    for (genvar n = 1; n < LEAVES; n++) begin : g_node
        logic take_left;
        assign take_left = nodes[2*n].k.vld &&
                           (!nodes[2*n+1].k.vld ||
                            !key_less(nodes[2*n+1].k, nodes[2*n].k));
        assign nodes[n] = take_left ? nodes[2*n] : nodes[2*n+1];
    end

    assign best_vld = nodes[1].k.vld;
    assign best_idx = nodes[1].k.vld ? nodes[1].idx : '0;
    assign best_grp = nodes[1].k.grp;

endmodule

// File: rtl/gpa_preempt_check.sv
module gpa_preempt_check
    import gpa_pkg::*;
(
    input  logic  win_vld,
    input  prio_t win_grp,
    input  logic  act_valid,
    input  prio_t act_prio,
    input  sel_t  split_sel,
    output logic  preempt
);

    prio_t act_grp;
    assign act_grp = grp_of(act_prio, split_sel);

    always_comb begin
        if (!win_vld)        preempt = 1'b0;
        else if (!act_valid) preempt = 1'b1;
        else                 preempt = (win_grp < act_grp);
    end

endmodule

// File: rtl/gpa_arbiter.sv
module gpa_arbiter
    import gpa_pkg::*;
#(
    parameter int NUM_REQ = 16,
    localparam int IW     = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_REQ-1:0]        req,
    input  logic [NUM_REQ*PRIO_W-1:0] prio_flat,
    input  logic [SEL_W-1:0]          split_sel,
    input  logic                      act_valid,
    input  logic [PRIO_W-1:0]         act_prio,
    output logic                      win_valid,
    output logic [IW-1:0]             win_idx,
    output logic                      preempt
);

    key_t [NUM_REQ-1:0] keys;
    logic               sel_vld;
    logic [IW-1:0]      sel_idx;
    prio_t              sel_grp;
    logic               sel_pre;

    gpa_key_split #(.NUM_REQ(NUM_REQ)) u_split (
        .req       (req),
        .prio_flat (prio_flat),
        .split_sel (split_sel),
        .keys      (keys)
    );

    gpa_select_tree #(.NUM_REQ(NUM_REQ)) u_tree (
        .keys     (keys),
        .best_vld (sel_vld),
        .best_idx (sel_idx),
        .best_grp (sel_grp)
    );

    gpa_preempt_check u_pre (
        .win_vld   (sel_vld),
        .win_grp   (sel_grp),
        .act_valid (act_valid),
        .act_prio  (act_prio),
        .split_sel (split_sel),
        .preempt   (sel_pre)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            win_valid <= 1'b0;
            win_idx   <= '0;
            preempt   <= 1'b0;
        end else begin
            win_valid <= sel_vld;
            win_idx   <= sel_idx;
            preempt   <= sel_pre;
        end
    end

endmodule

// File: rtl/gpa_arbiter_chk.sv
module gpa_arbiter_chk
    import gpa_pkg::*;
#(
    parameter int NUM_REQ = 16,
    localparam int IW     = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input logic                      clk,
    input logic                      rst,
    input logic [NUM_REQ-1:0]        req,
    input logic [NUM_REQ*PRIO_W-1:0] prio_flat,
    input logic [SEL_W-1:0]          split_sel,
    input logic                      act_valid,
    input logic [PRIO_W-1:0]         act_prio,
    input logic                      win_valid,
    input logic [IW-1:0]             win_idx,
    input logic                      preempt
);

    logic                      armed;
    logic [NUM_REQ-1:0]        req_q;
    logic [NUM_REQ*PRIO_W-1:0] prio_q;
    sel_t                      sel_q;
    logic                      act_vld_q;
    prio_t                     act_q;

    always_ff @(posedge clk) begin
        armed     <= !rst;
        req_q     <= req;
        prio_q    <= prio_flat;
        sel_q     <= split_sel;
        act_vld_q <= act_valid;
        act_q     <= act_prio;
    end

    prio_t win_val;
    assign win_val = prio_q[win_idx*PRIO_W +: PRIO_W];

    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (!win_valid && win_idx == '0 && !preempt));

    p_valid_tracks_r2: assert property (@(posedge clk) disable iff (rst)
        armed |-> (win_valid == (|req_q)));

    p_winner_requested_r11: assert property (@(posedge clk) disable iff (rst)
        (armed && win_valid) |-> req_q[win_idx]);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !win_valid |-> (!preempt && win_idx == '0));

    p_free_take_r9: assert property (@(posedge clk) disable iff (rst)
        (armed && !act_vld_q) |-> (preempt == win_valid));

    p_group_only_r8: assert property (@(posedge clk) disable iff (rst)
        (armed && win_valid && act_vld_q) |->
            (preempt == (grp_of(win_val, sel_q) < grp_of(act_q, sel_q))));

endmodule

bind gpa_arbiter gpa_arbiter_chk #(.NUM_REQ(NUM_REQ)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .prio_flat (prio_flat),
    .split_sel (split_sel),
    .act_valid (act_valid),
    .act_prio  (act_prio),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .preempt   (preempt)
);

// File: tb/gpa_arbiter_bench.sv
module gpa_arbiter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 16;
    localparam int PW = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    req = '0;
    logic [PW-1:0]   pv [N];
    logic [N*PW-1:0] prio_flat;
    logic [2:0]      split_sel = 3'd0;
    logic            act_valid = 1'b0;
    logic [PW-1:0]   act_prio  = '0;
    logic            win_valid;
    logic [3:0]      win_idx;
    logic            preempt;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb
        for (int i = 0; i < N; i++) prio_flat[i*PW +: PW] = pv[i];

    gpa_arbiter #(.NUM_REQ(N)) u_gpa_arbiter (
        .clk(clk), .rst(rst), .req(req), .prio_flat(prio_flat),
        .split_sel(split_sel), .act_valid(act_valid), .act_prio(act_prio),
        .win_valid(win_valid), .win_idx(win_idx), .preempt(preempt)
    );

    task automatic expect_out(input string tag, input logic ev,
                              input logic [3:0] ei, input logic ep);
        checks++;
        if (win_valid !== ev || win_idx !== ei || preempt !== ep) begin
            failures++;
            $display("FAIL %s: got valid=%0b idx=%0d pre=%0b, want valid=%0b idx=%0d pre=%0b",
                     tag, win_valid, win_idx, preempt, ev, ei, ep);
        end
    endtask

    task automatic clear_lines();
        req = '0;
        for (int i = 0; i < N; i++) pv[i] = 8'hFF;
    endtask

    // inputs applied at falling edge, result sampled just after next rise
    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        step();
        expect_out("R1 reset", 1'b0, 4'd0, 1'b0);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_none();
        @(negedge clk); clear_lines(); act_valid = 1'b0;
        step();
        expect_out("R10 no request", 1'b0, 4'd0, 1'b0);
    endtask

    task automatic t_latency();
        @(negedge clk); clear_lines(); pv[5] = 8'h40; req[5] = 1'b1;
        #1;
        expect_out("R2 before edge", 1'b0, 4'd0, 1'b0);
        step();
        expect_out("R2 R9 single line", 1'b1, 4'd5, 1'b1);
    endtask

    task automatic t_value();
        @(negedge clk); clear_lines(); split_sel = 3'd4;
        pv[3] = 8'h80; pv[9] = 8'h20; req[3] = 1'b1; req[9] = 1'b1;
        step();
        expect_out("R3 smaller group", 1'b1, 4'd9, 1'b1);
        @(negedge clk); clear_lines();
        pv[0] = 8'h11; pv[15] = 8'h00; req[0] = 1'b1; req[15] = 1'b1;
        step();
        expect_out("R3 high index wins", 1'b1, 4'd15, 1'b1);
    endtask

    task automatic t_masked();
        @(negedge clk); clear_lines(); split_sel = 3'd4;
        pv[2] = 8'h00; pv[3] = 8'h80; pv[9] = 8'h20;
        req[3] = 1'b1; req[9] = 1'b1;
        step();
        expect_out("R11 idle line ignored", 1'b1, 4'd9, 1'b1);
    endtask

    task automatic t_sub();
        @(negedge clk); clear_lines(); split_sel = 3'd4;
        pv[1] = 8'h35; pv[7] = 8'h32; req[1] = 1'b1; req[7] = 1'b1;
        act_valid = 1'b1; act_prio = 8'h40;
        step();
        expect_out("R5 R7 sub-level, group below", 1'b1, 4'd7, 1'b1);
        @(negedge clk); act_prio = 8'h3F;
        step();
        expect_out("R8 same group no preempt", 1'b1, 4'd7, 1'b0);
        @(negedge clk); clear_lines();
        pv[2] = 8'h2F; pv[10] = 8'h21; req[2] = 1'b1; req[10] = 1'b1;
        act_prio = 8'h20;
        step();
        expect_out("R5 R8 sub beats index", 1'b1, 4'd10, 1'b0);
    endtask

    task automatic t_split();
        @(negedge clk); clear_lines(); split_sel = 3'd0;
        pv[6] = 8'h32; req[6] = 1'b1; act_valid = 1'b1; act_prio = 8'h33;
        step();
        expect_out("R4 sel0 one step below", 1'b1, 4'd6, 1'b1);
        @(negedge clk); act_prio = 8'h32;
        step();
        expect_out("R4 R8 sel0 equal", 1'b1, 4'd6, 1'b0);
        @(negedge clk); split_sel = 3'd1;
        act_prio = 8'h33;
        step();
        expect_out("R4 sel1 merges pair", 1'b1, 4'd6, 1'b0);
        @(negedge clk); clear_lines(); split_sel = 3'd7;
        pv[4] = 8'h10; req[4] = 1'b1; act_prio = 8'h70;
        step();
        expect_out("R4 R8 sel7 same half", 1'b1, 4'd4, 1'b0);
        @(negedge clk); act_prio = 8'h80;
        step();
        expect_out("R4 R7 sel7 other half", 1'b1, 4'd4, 1'b1);
    endtask

    task automatic t_tie();
        @(negedge clk); clear_lines(); split_sel = 3'd3; act_valid = 1'b0;
        pv[6] = 8'h50; pv[11] = 8'h50; pv[14] = 8'h50;
        req[6] = 1'b1; req[11] = 1'b1; req[14] = 1'b1;
        step();
        expect_out("R6 tie lowest index", 1'b1, 4'd6, 1'b1);
        @(negedge clk); clear_lines();
        pv[0] = 8'h77; pv[15] = 8'h77; req[0] = 1'b1; req[15] = 1'b1;
        act_valid = 1'b1; act_prio = 8'h90;
        step();
        expect_out("R6 R7 tie ends", 1'b1, 4'd0, 1'b1);
    endtask

    task automatic t_reset_again();
        @(negedge clk); rst = 1'b1;
        step();
        expect_out("R1 reset mid-run", 1'b0, 4'd0, 1'b0);
        @(negedge clk); rst = 1'b0; clear_lines();
        step();
        expect_out("R10 empty after reset", 1'b0, 4'd0, 1'b0);
    endtask

    initial begin
        clear_lines();
        t_reset();
        t_none();
        t_latency();
        t_value();
        t_masked();
        t_sub();
        t_split();
        t_tie();
        t_reset_again();
        done = 1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got hung, want completion");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule